// File: doc/BRIEF.md
# Posted-CAS Read/Write Latency Pipeline

This block sits on the controller side of a double-data-rate memory interface. It turns column read and write commands into per-cycle enables. A read enable marks the clock cycles in which read data will come back. A write enable marks the cycles in which write data and its strobe must be driven. Each enable carries the two burst-beat column indices for the rising and falling halves of the cycle.

The read latency is the sum of a programmable additive latency and a programmable CAS latency. The write latency is always one cycle shorter than the read latency. Each command carries its own burst length of 4 or 8 beats. The burst ordering, sequential or interleaved, is part of the latency setting.

Commands are placed into two timelines, one for reads and one for writes. Several bursts can be in flight at once, and bursts placed back to back form one unbroken window.

The controller must avoid two situations, and the block reports both:
- A write whose data window would collide with a pending read window is dropped and reported.
- A latency change attempted while any burst is pending is refused and recorded in a sticky error bit.

Top module: `ddr_lat_pipe`

## Requirements
- R1: After reset the enables, the collision pulse and the error bit are 0. The setting is CAS latency 3, additive latency 0, sequential order, so a read issued straight after reset opens its window 3 cycles later.
- R2: A setting write while idle is taken only if the CAS latency is 3, 4 or 5 and the additive latency is 0 to 4. Any other value leaves the whole previous setting, including the order, in force. A taken setting applies to commands from the next cycle on.
- R3: A read accepted at clock edge E opens `rd_valid` in the cycle that starts at edge E+RL-1, where RL = AL + CL. That cycle is the RL-th cycle counted from the command cycle. The window lasts 2 cycles for a 4-beat burst and 4 cycles for an 8-beat burst.
- R4: A scheduled write opens `wr_valid` one cycle earlier than a read issued under the same setting would (WL = RL - 1). Its window has the same length as a read window.
- R5: Sequential order: beat k (k = 0..N-1, two beats per cycle, k = 2j on `*_beat0` and 2j+1 on `*_beat1` in the j-th window cycle) has index {c[2] XOR k[2], (c[1:0] + k[1:0]) mod 4}, where c is the start column. For a 4-beat burst k[2] = 0, so bit 2 stays c[2].
- R6: Interleaved order: beat k has index c XOR k, using the same beat numbering as R5.
- R7: A burst issued exactly one window length after the previous one of the same kind gives an unbroken enable window. Where two windows of the same kind share a cycle, the newer command's beat indices are shown.
- R8: A write whose window would share any cycle with a pending read window is not scheduled: it produces no `wr_valid` cycle. It raises `wr_conflict` for exactly the one cycle after the command.
- R9: A setting write while any burst is pending, or while a command is presented in the same cycle, is refused. It sets `cfg_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_we | input | 1 | Request to load a new latency setting |
| set_cl | input | 3 | CAS latency requested (3..5) |
| set_al | input | 3 | Additive latency requested (0..4) |
| set_ilv | input | 1 | Burst order requested: 1 interleaved, 0 sequential |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_bl8 | input | 1 | 1 for an 8-beat burst, 0 for 4 beats |
| cmd_col | input | 3 | Low column address bits that start the burst |
| rd_valid | output | 1 | Read data expected this cycle |
| rd_beat0 | output | 3 | Column index of the first beat of this cycle's read pair |
| rd_beat1 | output | 3 | Column index of the second beat of this cycle's read pair |
| wr_valid | output | 1 | Write data and strobe to be driven this cycle |
| wr_beat0 | output | 3 | Column index of the first beat of this cycle's write pair |
| wr_beat1 | output | 3 | Column index of the second beat of this cycle's write pair |
| wr_conflict | output | 1 | One-cycle pulse: last write was dropped for colliding with a read |
| cfg_err | output | 1 | Sticky: a setting change was attempted while busy |

## Verification
A wrong slot in either timeline shows up at the ports as an enable that opens one or more cycles early or late, or as a window with a gap. It can also appear as wrong beat indices on the pair outputs. All of these appear within RL plus four cycles of the command that caused them. A corrupted latency setting shifts every later window and goes unnoticed until the next command drains. A bad collision probe shows up as a missing `wr_conflict` pulse in the cycle after the write, or as a write window overlapping a read. The bench compares every output against a reference timeline every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/lat_pkg.sv
// Package lat_pkg
// Shared limits, the timeline slot type and the beat-order function used
// by the latency pipeline. Assumes 3 low column bits, i.e. bursts of at
// most 8 beats carried two per clock.
package lat_pkg;

    localparam int CL_MIN   = 3;
    localparam int CL_MAX   = 5;
    localparam int AL_MAX   = 4;
    localparam int HALF_MAX = 4;   // clock cycles of the longest burst
    localparam int LATW     = 3;   // width of the latency fields
    localparam int COLW     = 3;   // width of a beat index

    typedef struct packed {
        logic            v;
        logic [COLW-1:0] b0;
        logic [COLW-1:0] b1;
    } slot_t;

    // Column index of beat k for start column c under the chosen order.
    function automatic logic [COLW-1:0] beat_idx(input logic [COLW-1:0] c,
                                                 input logic [COLW-1:0] k,
                                                 input logic            ilv);
        logic [1:0] low;
        low = c[1:0] + k[1:0];
        if (ilv)
            return c ^ k;
        else
            return {c[2] ^ k[2], low};
    endfunction

endpackage

// File: rtl/lat_cfg.sv
// Module lat_cfg
// Holds the CAS latency, additive latency and burst order. A new setting is
// taken only when the block is idle and both latencies are in range; a
// request while busy is refused and recorded in a sticky error bit.
// Assumes `busy` already includes a command presented this cycle.
module lat_cfg
    import lat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_we,
    input  logic [LATW-1:0] set_cl,
    input  logic [LATW-1:0] set_al,
    input  logic            set_ilv,
    input  logic            busy,
    output logic [3:0]      rl,
    output logic            ilv,
    output logic            err
);

    logic [LATW-1:0] cl_q;
    logic [LATW-1:0] al_q;
    logic            ilv_q;
    logic            err_q;
    logic            in_range;
    logic            take;

    // Range check of the requested latencies.
    always_comb begin
        in_range = (int'(set_cl) >= CL_MIN) && (int'(set_cl) <= CL_MAX)
                && (int'(set_al) <= AL_MAX);
        take     = set_we && !busy && in_range;
    end

    // Setting registers, loaded only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q  <= LATW'(CL_MIN);
            al_q  <= '0;
            ilv_q <= 1'b0;
        end else if (take) begin
            cl_q  <= set_cl;
            al_q  <= set_al;
            ilv_q <= set_ilv;
        end
    end

    // Sticky record of a change attempted while bursts are pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (set_we && busy)
            err_q <= 1'b1;
    end

    assign rl  = 4'(cl_q) + 4'(al_q);
    assign ilv = ilv_q;
    assign err = err_q;

    a_r2_cl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cl_q) >= CL_MIN) && (int'(cl_q) <= CL_MAX));

    a_r2_al_legal: assert property (@(posedge clk) disable iff (!rst_n)
        int'(al_q) <= AL_MAX);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && busy) |=> ($stable(cl_q) && $stable(al_q) && $stable(ilv_q)));

endmodule

// File: rtl/lat_slot_pipe.sv
// Module lat_slot_pipe
// A timeline of DEPTH clock slots that shifts one slot toward the output
// every cycle. An insertion fills N/2 consecutive slots from ins_base
// (counted after the shift) with the burst's beat pairs; a newer insertion
// overwrites any slot it shares. Slot 0 drives the outputs.
module lat_slot_pipe
    import lat_pkg::*;
#(
    parameter int DEPTH = 13,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_en,
    input  logic [IDXW-1:0] ins_base,
    input  logic            ins_bl8,
    input  logic [COLW-1:0] ins_col,
    input  logic            ins_ilv,
    output logic            out_valid,
    output logic [COLW-1:0] out_b0,
    output logic [COLW-1:0] out_b1,
    output logic [DEPTH-1:0] occ
);

    slot_t q   [DEPTH];
    slot_t nxt [DEPTH];

    // Next content of every slot: shifted neighbour or a new beat pair.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int    rel;
            int    n2;
            slot_t sh;
            n2  = ins_bl8 ? HALF_MAX : HALF_MAX / 2;
            rel = i - int'(ins_base);
            if (i < DEPTH - 1)
                sh = q[(i + 1) % DEPTH];
            else
                sh = '0;
            if (ins_en && rel >= 0 && rel < n2) begin
                nxt[i].v  = 1'b1;
                nxt[i].b0 = beat_idx(ins_col, COLW'(2 * rel), ins_ilv);
                nxt[i].b1 = beat_idx(ins_col, COLW'(2 * rel + 1), ins_ilv);
            end else begin
                nxt[i] = sh;
            end
        end
    end

    // Slot registers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                q[i] <= '0;
            else
                q[i] <= nxt[i];
        end
    end

    // Occupancy vector for probing and the idle test.
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            occ[i] = q[i].v;
    end

    assign out_valid = q[0].v;
    assign out_b0    = q[0].b0;
    assign out_b1    = q[0].b1;

    a_r3_slot_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (q[1].v && !ins_en) |=> out_valid);

    a_r3_tail_empty_unless_fed: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_en |=> !q[DEPTH-1].v);

endmodule

// File: rtl/lat_probe.sv
// Module lat_probe
// Tests whether any of the N/2 slots starting at `base` in an occupancy
// vector is taken. Used to see if a write window would meet a read window.
// Assumes base + N/2 stays below DEPTH for every legal setting.
module lat_probe
    import lat_pkg::*;
#(
    parameter int DEPTH = 13,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] occ,
    input  logic [IDXW-1:0]  base,
    input  logic             bl8,
    output logic             hit
);

    // OR of the occupied slots inside the probed window.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            int rel;
            rel = i - int'(base);
            if (rel >= 0 && rel < (bl8 ? HALF_MAX : HALF_MAX / 2) && occ[i])
                hit = 1'b1;
        end
    end

endmodule

// File: rtl/ddr_lat_pipe.sv
// Module ddr_lat_pipe
// Top of the posted-CAS latency pipeline. Reads enter the read timeline at
// RL-1 slots ahead, writes enter the write timeline at RL-2 slots ahead
// (WL = RL-1). A write is first probed against the pending read slots it
// would occupy; a collision drops it and pulses wr_conflict. Assumes at
// most one command per cycle and RL >= 3.
module ddr_lat_pipe
    import lat_pkg::*;
#(
    parameter int DEPTH = CL_MAX + AL_MAX + HALF_MAX,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_we,
    input  logic [2:0]      set_cl,
    input  logic [2:0]      set_al,
    input  logic            set_ilv,
    input  logic            cmd_valid,
    input  logic            cmd_write,
    input  logic            cmd_bl8,
    input  logic [2:0]      cmd_col,
    output logic            rd_valid,
    output logic [2:0]      rd_beat0,
    output logic [2:0]      rd_beat1,
    output logic            wr_valid,
    output logic [2:0]      wr_beat0,
    output logic [2:0]      wr_beat1,
    output logic            wr_conflict,
    output logic            cfg_err
);

    logic [3:0]       rl;
    logic             ilv;
    logic             busy;
    logic [DEPTH-1:0] rd_occ;
    logic [DEPTH-1:0] wr_occ;
    logic [IDXW-1:0]  rd_base;
    logic [IDXW-1:0]  wr_base;
    logic             clash;
    logic             rd_ins;
    logic             wr_ins;
    logic             conflict_q;

    // Idle test: nothing pending in either timeline and no command now.
    always_comb busy = (|rd_occ) || (|wr_occ) || cmd_valid;

    // Insertion points and enables for the two timelines.
    always_comb begin
        rd_base = IDXW'(rl - 4'd1);
        wr_base = IDXW'(rl - 4'd2);
        rd_ins  = cmd_valid && !cmd_write;
        wr_ins  = cmd_valid && cmd_write && !clash;
    end

    lat_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (set_we),
        .set_cl  (set_cl),
        .set_al  (set_al),
        .set_ilv (set_ilv),
        .busy    (busy),
        .rl      (rl),
        .ilv     (ilv),
        .err     (cfg_err)
    );

    // Before the shift, a write's window sits at slots RL-1.. of the read line.
    lat_probe #(.DEPTH(DEPTH), .IDXW(IDXW)) u_probe (
        .occ  (rd_occ),
        .base (rd_base),
        .bl8  (cmd_bl8),
        .hit  (clash)
    );

    lat_slot_pipe #(.DEPTH(DEPTH), .IDXW(IDXW)) u_rd_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_en    (rd_ins),
        .ins_base  (rd_base),
        .ins_bl8   (cmd_bl8),
        .ins_col   (cmd_col),
        .ins_ilv   (ilv),
        .out_valid (rd_valid),
        .out_b0    (rd_beat0),
        .out_b1    (rd_beat1),
        .occ       (rd_occ)
    );

    lat_slot_pipe #(.DEPTH(DEPTH), .IDXW(IDXW)) u_wr_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_en    (wr_ins),
        .ins_base  (wr_base),
        .ins_bl8   (cmd_bl8),
        .ins_col   (cmd_col),
        .ins_ilv   (ilv),
        .out_valid (wr_valid),
        .out_b0    (wr_beat0),
        .out_b1    (wr_beat1),
        .occ       (wr_occ)
    );

    // One-cycle report of a dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            conflict_q <= 1'b0;
        else
            conflict_q <= cmd_valid && cmd_write && clash;
    end

    assign wr_conflict = conflict_q;

    a_r8_dropped_write_leaves_line: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write && clash) |=> $stable(wr_occ[DEPTH-2:0]) || (wr_occ[DEPTH-2:0] == $past(wr_occ[DEPTH-1:1])));

    a_r1_quiet_out_of_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rd_valid && !wr_valid && !wr_conflict && !cfg_err));

endmodule

// File: tb/ddr_lat_pipe_tb.sv
// Bench for ddr_lat_pipe: directed corner cases followed by seeded random
// traffic, every output compared each cycle against a reference timeline
// built from the requirements.
module ddr_lat_pipe_tb;

    localparam int CLK_PERIOD = 10;
    localparam int D          = 13;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       set_we, set_ilv, cmd_valid, cmd_write, cmd_bl8;
    logic [2:0] set_cl, set_al, cmd_col;
    logic       rd_valid, wr_valid, wr_conflict, cfg_err;
    logic [2:0] rd_beat0, rd_beat1, wr_beat0, wr_beat1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference state
    bit       rv [D];
    bit [2:0] rb0 [D];
    bit [2:0] rb1 [D];
    bit       wv [D];
    bit [2:0] wb0 [D];
    bit [2:0] wb1 [D];
    int       m_cl, m_al;
    bit       m_ilv, m_err, m_conf;

    // observation helpers
    int    first_rd, first_wr, run, max_run, wr_hi;
    string focus = "";

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr_lat_pipe u_dut (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .set_cl(set_cl), .set_al(set_al), .set_ilv(set_ilv),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_bl8(cmd_bl8), .cmd_col(cmd_col),
        .rd_valid(rd_valid), .rd_beat0(rd_beat0), .rd_beat1(rd_beat1),
        .wr_valid(wr_valid), .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
        .wr_conflict(wr_conflict), .cfg_err(cfg_err)
    );

    function automatic bit [2:0] exp_beat(bit [2:0] c, int k, bit il);
        bit [2:0] kk;
        kk = 3'(k);
        if (il) return c ^ kk;
        return {c[2] ^ kk[2], 2'(c[1:0] + kk[1:0])};
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, focus, act, exp, cyc);
        end
    endtask

    task automatic compare();
        check("R3 rd_valid", int'(rd_valid), int'(rv[0]));
        if (rv[0]) begin
            check("R5/R6 rd_beat0", int'(rd_beat0), int'(rb0[0]));
            check("R5/R6 rd_beat1", int'(rd_beat1), int'(rb1[0]));
        end
        check("R4 wr_valid", int'(wr_valid), int'(wv[0]));
        if (wv[0]) begin
            check("R5/R6 wr_beat0", int'(wr_beat0), int'(wb0[0]));
            check("R5/R6 wr_beat1", int'(wr_beat1), int'(wb1[0]));
        end
        check("R8 wr_conflict", int'(wr_conflict), int'(m_conf));
        check("R9 cfg_err", int'(cfg_err), int'(m_err));
        if (rd_valid && first_rd < 0) first_rd = cyc;
        if (wr_valid && first_wr < 0) first_wr = cyc;
        if (wr_valid) wr_hi++;
        run = rd_valid ? run + 1 : 0;
        if (run > max_run) max_run = run;
    endtask

    // One clock: drive at the falling edge, update the reference at the
    // rising edge, compare at the next falling edge.
    task automatic tick(bit v, bit w, bit b8, bit [2:0] col,
                        bit cwe, bit [2:0] ccl, bit [2:0] cal, bit cil);
        bit busy_m, clash_m;
        int n2;
        cmd_valid = v; cmd_write = w; cmd_bl8 = b8; cmd_col = col;
        set_we = cwe; set_cl = ccl; set_al = cal; set_ilv = cil;
        n2 = b8 ? 4 : 2;
        busy_m = v;
        for (int i = 0; i < D; i++) if (rv[i] || wv[i]) busy_m = 1;
        clash_m = 0;
        if (v && w)
            for (int j = 0; j < n2; j++) if (rv[m_cl + m_al - 1 + j]) clash_m = 1;
        @(posedge clk);
        for (int i = 0; i < D - 1; i++) begin
            rv[i] = rv[i+1]; rb0[i] = rb0[i+1]; rb1[i] = rb1[i+1];
            wv[i] = wv[i+1]; wb0[i] = wb0[i+1]; wb1[i] = wb1[i+1];
        end
        rv[D-1] = 0; wv[D-1] = 0;
        if (v && !w)
            for (int j = 0; j < n2; j++) begin
                rv[m_cl + m_al - 1 + j]  = 1;
                rb0[m_cl + m_al - 1 + j] = exp_beat(col, 2*j, m_ilv);
                rb1[m_cl + m_al - 1 + j] = exp_beat(col, 2*j + 1, m_ilv);
            end
        if (v && w && !clash_m)
            for (int j = 0; j < n2; j++) begin
                wv[m_cl + m_al - 2 + j]  = 1;
                wb0[m_cl + m_al - 2 + j] = exp_beat(col, 2*j, m_ilv);
                wb1[m_cl + m_al - 2 + j] = exp_beat(col, 2*j + 1, m_ilv);
            end
        m_conf = v && w && clash_m;
        if (cwe) begin
            if (busy_m) m_err = 1;
            else if (ccl >= 3 && ccl <= 5 && cal <= 4) begin
                m_cl = int'(ccl); m_al = int'(cal); m_ilv = cil;
            end
        end
        cyc++;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 3'd0, 0, 3'd0, 3'd0, 0);
    endtask

    task automatic setcfg(bit [2:0] c, bit [2:0] a, bit il);
        tick(0, 0, 0, 3'd0, 1, c, a, il);
    endtask

    // Issue a read and return its measured latency after draining.
    task automatic rd_latency(bit [2:0] col, output int lat);
        int c0;
        first_rd = -1;
        tick(1, 0, 0, col, 0, 3'd0, 3'd0, 0);
        c0 = cyc;
        idle(14);
        lat = first_rd - c0 + 1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int lat;
        void'($urandom(32'h5eed_2024));
        for (int i = 0; i < D; i++) begin rv[i] = 0; wv[i] = 0; rb0[i] = 0; rb1[i] = 0; wb0[i] = 0; wb1[i] = 0; end
        m_cl = 3; m_al = 0; m_ilv = 0; m_err = 0; m_conf = 0;
        first_rd = -1; first_wr = -1; run = 0; max_run = 0; wr_hi = 0;
        rst_n = 0;
        cmd_valid = 0; cmd_write = 0; cmd_bl8 = 0; cmd_col = 0;
        set_we = 0; set_cl = 0; set_al = 0; set_ilv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        focus = "R1 reset state";
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 wr_valid", int'(wr_valid), 0);
        check("R1 wr_conflict", int'(wr_conflict), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        rd_latency(3'd0, lat);
        check("R1 default read latency", lat, 3);

        focus = "R2 legal setting";
        setcfg(3'd4, 3'd1, 0);
        rd_latency(3'd1, lat);
        check("R2 R3 latency CL4 AL1", lat, 5);
        focus = "R2 illegal CL";
        setcfg(3'd6, 3'd2, 1);
        rd_latency(3'd2, lat);
        check("R2 latency kept", lat, 5);
        focus = "R2 illegal AL";
        setcfg(3'd5, 3'd5, 0);
        rd_latency(3'd3, lat);
        check("R2 latency kept", lat, 5);

        focus = "R4 write latency";
        first_wr = -1;
        tick(1, 1, 0, 3'd2, 0, 3'd0, 3'd0, 0);
        lat = cyc;
        idle(14);
        check("R4 write latency", first_wr - lat + 1, 4);

        focus = "R7 back-to-back reads";
        max_run = 0;
        tick(1, 0, 1, 3'd5, 0, 3'd0, 3'd0, 0);
        idle(3);
        tick(1, 0, 0, 3'd3, 0, 3'd0, 3'd0, 0);
        idle(14);
        check("R7 unbroken window", max_run, 6);

        focus = "R6 interleaved BL8";
        setcfg(3'd5, 3'd4, 1);
        tick(1, 0, 1, 3'd6, 0, 3'd0, 3'd0, 0);
        tick(0, 0, 0, 3'd0, 0, 3'd0, 3'd0, 0);
        idle(3);
        tick(1, 1, 1, 3'd3, 0, 3'd0, 3'd0, 0);
        idle(16);

        focus = "R8 write onto read";
        setcfg(3'd4, 3'd1, 0);
        wr_hi = 0;
        tick(1, 0, 0, 3'd0, 0, 3'd0, 3'd0, 0);
        tick(1, 1, 0, 3'd1, 0, 3'd0, 3'd0, 0);
        check("R8 pulse", int'(wr_conflict), 1);
        idle(1);
        check("R8 single pulse", int'(wr_conflict), 0);
        idle(14);
        check("R8 dropped write never driven", wr_hi, 0);

        focus = "R9 change while busy";
        tick(1, 0, 0, 3'd0, 0, 3'd0, 3'd0, 0);
        setcfg(3'd3, 3'd0, 0);
        idle(14);
        check("R9 error sticky", int'(cfg_err), 1);
        rd_latency(3'd0, lat);
        check("R9 setting unchanged", lat, 5);

        focus = "random";
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3)
                tick(0, 0, 0, 3'd0, 1, 3'($urandom_range(2, 6)), 3'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
            else if (r < 40)
                tick(1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                     0, 3'd0, 3'd0, 0);
            else
                idle(1);
        end
        idle(16);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule